// File: doc/BRIEF.md
# Multi-Rail Supply Supervisor Sequencer

This block is the digital housekeeping controller of a power supply with three output rails. Comparators outside the block report, one flag per rail, whether each rail is above its upper limit or below its lower limit. An extra over-limit flag from an auxiliary sense point and a flag saying the input power is present complete the inputs. The block combines these flags with a synchronised on/off request from the host. From them it drives a latched shutdown command to the primary converter and a range-warning level toward the host. Every delay is a number of clock cycles and is set by a parameter.

Over-limit and under-limit conditions are treated differently. An under-limit flag is ignored while the supply is coming up, during a blanking window. After that window it trips the shutdown latch at once. An over-limit flag is never blanked, but it must stay up for a filter time before it trips the latch. Only a remote request that outlasts a qualification time can clear the latch. When the remote request is released, the supervisor starts again from blanking.

The controller has four states. `ST_BLANK` is the power-up window. `ST_RUN` is normal supervision. `ST_LATCHED` means a fault has been caught. `ST_REMOTE_OFF` means the host has switched the supply off. The transitions are:
- blank-expire: `ST_BLANK`→`ST_RUN`.
- ov-trip: `ST_BLANK` or `ST_RUN`→`ST_LATCHED`.
- uv-trip: `ST_RUN`→`ST_LATCHED`.
- remote-on: any other state→`ST_REMOTE_OFF`.
- remote-release: `ST_REMOTE_OFF`→`ST_BLANK`.

When more than one transition applies, remote-on wins.

Top module: `supply_supervisor`

## Requirements
- R1: On reset, `fault_off` is 0, `range_warn` is 1 and the controller is in the blanking window.
- R2: A raised bit of `ov_rail[2:0]` (one bit per rail), or a raised `ov_aux`, sets the fault latch if some over-limit flag has stayed up for OV_CYC consecutive clock edges. The latch is set on the edge after that. A shorter over-limit run has no effect.
- R3: For BLANK_CYC clock edges after reset, under-limit flags have no effect on `fault_off`.
- R4: Once blanking has expired, any raised bit of `uv_rail[2:0]` sets the fault latch on the next clock edge.
- R5: A set fault latch holds `fault_off` at 1 until an accepted remote request arrives.
- R6: `remote_req` takes effect only after it has held a new level for REM_CYC consecutive clock edges, both when it rises and when it falls. A shorter remote pulse changes neither output.
- R7: While the accepted remote level is 1, `fault_off` and `range_warn` are both 1 and the fault latch is cleared.
- R8: When the accepted remote level falls, `fault_off` returns to 0 and a fresh blanking window of BLANK_CYC edges begins, during which under-limit flags are again ignored.
- R9: `range_warn` follows the "out of range" condition, which is any over-limit flag, any under-limit flag, or `pwr_in_ok` low. It changes only after that condition has held its new value for PG_CYC consecutive clock edges, in either direction.
- R10: Over-limit flags are not blanked. A qualified over-limit run sets the latch during the blanking window too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ov_rail | input | 3 | Per-rail over-limit flags |
| ov_aux | input | 1 | Auxiliary over-limit flag |
| uv_rail | input | 3 | Per-rail under-limit flags |
| pwr_in_ok | input | 1 | Input power present |
| remote_req | input | 1 | Synchronised host off request, active high |
| fault_off | output | 1 | Converter shutdown command, high = off |
| range_warn | output | 1 | Delayed out-of-range warning to the host |

## Verification
The hardest situation to reach is the second blanking window, the one that follows a remote release. Getting there takes three steps: a remote request long enough to be accepted, then a release that is itself held long enough to be accepted, then an under-limit pulse placed inside the new window. The bench counts edges from the release and places that pulse a few edges into the restarted window. It then places another pulse after the window has expired and expects it to trip the latch. Pulse widths and arrival times are swept across each qualification boundary, and the expected result is computed as width compared against the parameter.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [1:0] {
        ST_BLANK      = 2'd0,
        ST_RUN        = 2'd1,
        ST_LATCHED    = 2'd2,
        ST_REMOTE_OFF = 2'd3
    } supv_state_t;
endpackage

// File: rtl/supv_hold_filter.sv
// Level qualifier: the output takes the input's value only after the input
// has differed from it for DLY consecutive clock edges.
module supv_hold_filter #(
    parameter int   DLY     = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_lvl,
    output logic q_lvl
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_lvl <= RST_VAL;
            cnt   <= '0;
        end else if (in_lvl == q_lvl) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            q_lvl <= in_lvl;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lvl == q_lvl) |=> $stable(q_lvl)); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LAST)); // R9
endmodule

// File: rtl/supv_blank_timer.sv
// Counts the blanking window while enabled; clears whenever disabled.
module supv_blank_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LAST)); // R3
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import supv_pkg::*;
#(
    parameter int NRAIL     = 3,
    parameter int BLANK_CYC = 60_000_000,
    parameter int OV_CYC    = 20_000,
    parameter int REM_CYC   = 10_000_000,
    parameter int PG_CYC    = 60_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRAIL-1:0] ov_rail,
    input  logic             ov_aux,
    input  logic [NRAIL-1:0] uv_rail,
    input  logic             pwr_in_ok,
    input  logic             remote_req,
    output logic             fault_off,
    output logic             range_warn
);
    supv_state_t state_q, state_d;

    logic ov_any, uv_any, bad_any;
    logic ov_qual, rem_q, pg_q, blank_done;

    assign ov_any  = (|ov_rail) | ov_aux;
    assign uv_any  = |uv_rail;
    assign bad_any = ov_any | uv_any | ~pwr_in_ok;

    supv_hold_filter #(.DLY(OV_CYC), .RST_VAL(1'b0)) u_ov_filt (
        .clk(clk), .rst_n(rst_n), .in_lvl(ov_any), .q_lvl(ov_qual));

    supv_hold_filter #(.DLY(REM_CYC), .RST_VAL(1'b0)) u_rem_filt (
        .clk(clk), .rst_n(rst_n), .in_lvl(remote_req), .q_lvl(rem_q));

    supv_hold_filter #(.DLY(PG_CYC), .RST_VAL(1'b1)) u_pg_filt (
        .clk(clk), .rst_n(rst_n), .in_lvl(bad_any), .q_lvl(pg_q));

    supv_blank_timer #(.CYCLES(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_BLANK), .done(blank_done));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: begin
                if (rem_q)           state_d = ST_REMOTE_OFF;
                else if (ov_qual)    state_d = ST_LATCHED;
                else if (blank_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (rem_q)                 state_d = ST_REMOTE_OFF;
                else if (ov_qual | uv_any) state_d = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (rem_q) state_d = ST_REMOTE_OFF;
            end
            ST_REMOTE_OFF: begin
                if (!rem_q) state_d = ST_BLANK;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    always_comb begin
        fault_off  = (state_q == ST_LATCHED) || (state_q == ST_REMOTE_OFF);
        range_warn = pg_q | rem_q;
    end

    AST_REMOTE_TAKES_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q |=> (state_q == ST_REMOTE_OFF)); // R7
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && !rem_q) |=> (state_q == ST_LATCHED)); // R5
    AST_UV_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && uv_any && !rem_q) |=> (state_q == ST_LATCHED)); // R4
    AST_UV_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !ov_qual && !rem_q && !blank_done)
            |=> (state_q == ST_BLANK)); // R3
    AST_RELEASE_REBLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REMOTE_OFF && !rem_q) |=> (state_q == ST_BLANK)); // R8
endmodule

// File: tb/supply_supervisor_bench.sv
module supply_supervisor_bench;
    localparam int BLANK = 8;
    localparam int OVD   = 4;
    localparam int REMD  = 3;
    localparam int PGD   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ov_rail = '0;
    logic       ov_aux = 1'b0;
    logic [2:0] uv_rail = '0;
    logic       pwr_in_ok = 1'b1;
    logic       remote_req = 1'b0;
    logic       fault_off, range_warn;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    supply_supervisor #(
        .NRAIL(3), .BLANK_CYC(BLANK), .OV_CYC(OVD), .REM_CYC(REMD), .PG_CYC(PGD)
    ) u_supply_supervisor (
        .clk(clk), .rst_n(rst_n), .ov_rail(ov_rail), .ov_aux(ov_aux),
        .uv_rail(uv_rail), .pwr_in_ok(pwr_in_ok), .remote_req(remote_req),
        .fault_off(fault_off), .range_warn(range_warn));

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ov_rail = '0; ov_aux = 1'b0; uv_rail = '0;
        pwr_in_ok = 1'b1; remote_req = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic set_ov(input int src, input logic v);
        if (src == 3) ov_aux = v;
        else          ov_rail[src] = v;
    endtask

    initial begin
        #900000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset values
        do_reset();
        check("R1 fault_off", fault_off, 1'b0);
        check("R1 range_warn", range_warn, 1'b1);

        // R9: warning clears after PGD good edges
        tick(PGD - 1);
        check("R9 warn held", range_warn, 1'b1);
        tick(1);
        check("R9 warn cleared", range_warn, 1'b0);

        // R9: sweep of bad-input run lengths
        for (int w = 1; w <= PGD + 2; w++) begin
            tick(BLANK);
            pwr_in_ok = 1'b0;
            tick(w);
            check($sformatf("R9 bad run %0d", w), range_warn, logic'(w >= PGD));
            pwr_in_ok = 1'b1;
            tick(PGD + 1);
            check($sformatf("R9 recovered %0d", w), range_warn, 1'b0);
        end

        // R3 / R4: under-limit pulse arriving at edge e after reset
        for (int r = 0; r < 3; r++) begin
            for (int e = 1; e <= BLANK + 4; e++) begin
                do_reset();
                tick(e - 1);
                uv_rail[r] = 1'b1;
                tick(1);
                uv_rail[r] = 1'b0;
                tick(1);
                check($sformatf("R3 R4 rail%0d edge%0d", r, e), fault_off,
                      logic'(e > BLANK));
            end
        end

        // R2: over-limit run length sweep, every source, after blanking
        for (int s = 0; s < 4; s++) begin
            for (int w = 1; w <= OVD + 2; w++) begin
                do_reset();
                tick(BLANK + 1);
                set_ov(s, 1'b1);
                tick(w);
                set_ov(s, 1'b0);
                tick(2);
                check($sformatf("R2 src%0d width%0d", s, w), fault_off,
                      logic'(w >= OVD));
            end
        end

        // R10: qualified over-limit inside blanking window
        do_reset();
        set_ov(1, 1'b1);
        tick(OVD);
        set_ov(1, 1'b0);
        tick(1);
        check("R10 ov trips in blanking", fault_off, 1'b1);
        tick(20);
        check("R5 latch holds", fault_off, 1'b1);

        // R5 / R6 / R7: remote pulse width needed to clear latch
        for (int w = 1; w <= REMD + 2; w++) begin
            do_reset();
            tick(BLANK + 1);
            uv_rail[0] = 1'b1;
            tick(1);
            uv_rail[0] = 1'b0;
            remote_req = 1'b1;
            tick(w);
            remote_req = 1'b0;
            tick(10);
            check($sformatf("R5 R6 clear width%0d", w), fault_off,
                  logic'(w < REMD));
        end

        // R6: short remote pulse from normal running is ignored
        do_reset();
        tick(BLANK + PGD);
        check("R9 good running", range_warn, 1'b0);
        remote_req = 1'b1;
        tick(REMD - 1);
        remote_req = 1'b0;
        tick(3);
        check("R6 short pulse fault", fault_off, 1'b0);
        check("R6 short pulse warn", range_warn, 1'b0);

        // R7: accepted remote forces both outputs high
        remote_req = 1'b1;
        tick(REMD);
        check("R7 remote warn", range_warn, 1'b1);
        tick(1);
        check("R7 remote fault", fault_off, 1'b1);
        tick(2);
        remote_req = 1'b0;
        tick(REMD - 1);
        check("R6 release not yet", fault_off, 1'b1);
        tick(2);
        check("R8 release fault", fault_off, 1'b0);

        // R8: blanking restarted after release
        tick(2);
        uv_rail[2] = 1'b1;
        tick(1);
        uv_rail[2] = 1'b0;
        tick(1);
        check("R8 uv blanked again", fault_off, 1'b0);
        tick(BLANK + 2);
        uv_rail[2] = 1'b1;
        tick(1);
        uv_rail[2] = 1'b0;
        tick(1);
        check("R4 uv after new blank", fault_off, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule